// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of a serial codec link. Software places 32-bit commands in a circular buffer in system memory and then moves a write pointer forward. While it is running, the engine reads each new entry through a single-request memory read port. It holds the entry on a valid/ready output until the link framer takes it, and only then advances its read pointer.

Software controls the engine through a small register port. The port has seven parts:
- a run bit whose readback reflects real idleness;
- an interrupt enable for memory faults;
- a ring-size select chosen among advertised capabilities;
- a 128-byte-aligned base address;
- the write pointer;
- a read-pointer view with a full flag and a two-phase reset handshake;
- a memory-error flag that is cleared by writing 1.

Top module: `cring_engine`

## Requirements
- R1: After reset the engine is stopped, both pointers and the error flag are 0, the irq output is 0, and the size select reads as the largest advertised size.
- R2: Register map, one register per `reg_addr` value:
  - 0: control. Bit 0 is run; bit 1 is the error interrupt enable.
  - 1: status. Bit 0 is the memory error flag.
  - 2: size. Bits 1:0 are the select, where 0 means 2 entries, 1 means 16 and 2 means 256. Bits 6:4 are the read-only capability (bit 4 for 2 entries, bit 5 for 16, bit 6 for 256).
  - 3: base address.
  - 4: write pointer, in bits 7:0.
  - 5: read pointer. Bits 7:0 hold the pointer, bit 14 is the full flag and bit 15 is the reset bit.
  A size select whose code is not advertised is ignored. Pointers wrap modulo the selected length.
- R3: A write to the size register while the run bit is 1 is ignored.
- R4: While running, the engine fetches the slots after the read pointer, up to and including the write pointer, in order. Each fetch reads the word at base + 4*slot, with one read outstanding at a time. It presents the word on `cmd_valid`/`cmd_data` until `cmd_ready`. The read pointer advances only on that acceptance.
- R5: The full flag (bit 14 of register 5) reads 1 exactly when (write pointer + 1) mod length equals the read pointer.
- R6: Writing 1 to bit 15 of register 5 clears the read pointer. Bit 15 then reads 1 once the pointer is 0 and the engine is idle. Writing 0 makes bit 15 read 0 again.
- R7: Clearing run stops further fetches. An outstanding fetch still completes and is delivered. Bit 0 of register 0 keeps reading 1 until the engine is idle.
- R8: While run is 1, a write to the write pointer whose value equals the current read pointer is ignored.
- R9: A read acknowledged with `mem_err` high does four things: it sets the error flag, clears run, presents nothing and leaves the read pointer unchanged. Writing 1 to status bit 0 clears the flag.
- R10: `irq` is high exactly while the error flag and its enable are both 1.
- R11: The low 7 bits of the base address always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the entry being fetched |
| mem_ack | input | 1 | Read data acknowledge |
| mem_rdata | input | DATA_W | Read data |
| mem_err | input | 1 | Read failed, qualified by mem_ack |
| cmd_valid | output | 1 | Command available for the link framer |
| cmd_data | output | DATA_W | Command word |
| cmd_ready | input | 1 | Link framer accepts the command |
| irq | output | 1 | Memory error interrupt |

## Verification
The bench builds the block with its defaults: all three ring sizes advertised, 32-bit data and addresses, and 128-byte base alignment. Because every size is available, the bench can move between 2-, 16- and 256-entry rings within one run. It wraps the pointers of each size: a few commands wrap the small rings, and about three hundred wrap the largest. It also fills a 16-entry ring to exactly its full boundary. A scoreboard compares every accepted command with what software queued, so any wrong address, order or repeated delivery shows up as a data mismatch. Downstream backpressure is varied to hold commands during the stop and ignored-write cases.

// File: rtl/cring_pkg.sv
package cring_pkg;

    localparam int PTR_W  = 8;
    localparam int REG_AW = 3;
    localparam int REG_W  = 32;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_STAT = 3'd1,
        RA_SIZE = 3'd2,
        RA_BASE = 3'd3,
        RA_WPTR = 3'd4,
        RA_RPTR = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SZ_2   = 2'd0,
        SZ_16  = 2'd1,
        SZ_256 = 2'd2
    } ring_size_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_HOLD = 2'd2
    } fetch_state_e;

    // control view handed from the register file to the fetch engine
    typedef struct packed {
        logic             run;
        logic             rst_req;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] mask;
    } ring_ctl_t;

    function automatic logic [PTR_W-1:0] size_mask(input logic [1:0] sel);
        case (sel)
            SZ_2:    return PTR_W'(1);
            SZ_16:   return PTR_W'(15);
            default: return PTR_W'(255);
        endcase
    endfunction

    function automatic logic size_ok(input logic [2:0] cap, input logic [1:0] sel);
        case (sel)
            SZ_2:    return cap[0];
            SZ_16:   return cap[1];
            SZ_256:  return cap[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] largest_size(input logic [2:0] cap);
        if (cap[2])      return SZ_256;
        else if (cap[1]) return SZ_16;
        else             return SZ_2;
    endfunction

endpackage

// File: rtl/cring_regs.sv
module cring_regs
    import cring_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [2:0]  SIZE_CAP   = 3'b111,
    parameter int          ALIGN_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [PTR_W-1:0]     rptr_i,
    input  logic                 busy_i,
    input  logic                 err_pulse_i,
    output logic [ADDR_W-1:0]    base_o,
    output ring_ctl_t            ctl_o,
    output logic                 irq_o
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

    logic              run_q;
    logic              ie_q;
    logic              err_q;
    logic              rst_q;
    logic [1:0]        sel_q;
    logic [PTR_W-1:0]  wptr_q;
    logic [ADDR_W-1:0] base_q;
    logic [PTR_W-1:0]  mask;
    logic              full;
    logic              rst_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            ie_q   <= 1'b0;
            err_q  <= 1'b0;
            rst_q  <= 1'b0;
            sel_q  <= largest_size(SIZE_CAP);
            wptr_q <= '0;
            base_q <= '0;
        end else begin
            if (err_pulse_i) begin
                err_q <= 1'b1;
                run_q <= 1'b0;
            end
            if (reg_we) begin
                case (reg_addr_e'(reg_addr))
                    RA_CTRL: begin
                        if (!err_pulse_i) run_q <= reg_wdata[0];
                        ie_q <= reg_wdata[1];
                    end
                    RA_STAT: begin
                        if (reg_wdata[0] && !err_pulse_i) err_q <= 1'b0;
                    end
                    RA_SIZE: begin
                        if (!run_q && size_ok(SIZE_CAP, reg_wdata[1:0]))
                            sel_q <= reg_wdata[1:0];
                    end
                    RA_BASE: base_q <= ADDR_W'(reg_wdata) & ~ALIGN_MASK;
                    RA_WPTR: begin
                        if (!(run_q && reg_wdata[PTR_W-1:0] == rptr_i))
                            wptr_q <= reg_wdata[PTR_W-1:0];
                    end
                    RA_RPTR: rst_q <= reg_wdata[15];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        mask    = size_mask(sel_q);
        full    = (((wptr_q + PTR_W'(1)) & mask) == rptr_i);
        rst_ack = rst_q && (rptr_i == '0) && !busy_i;
        case (reg_addr_e'(reg_addr))
            RA_CTRL: reg_rdata = {30'b0, ie_q, run_q | busy_i};
            RA_STAT: reg_rdata = {31'b0, err_q};
            RA_SIZE: reg_rdata = {25'b0, SIZE_CAP, 2'b00, sel_q};
            RA_BASE: reg_rdata = REG_W'(base_q);
            RA_WPTR: reg_rdata = REG_W'(wptr_q);
            RA_RPTR: reg_rdata = {16'b0, rst_ack, full, 6'b0, rptr_i};
            default: reg_rdata = '0;
        endcase
    end

    assign base_o        = base_q;
    assign ctl_o.run     = run_q;
    assign ctl_o.rst_req = rst_q;
    assign ctl_o.wptr    = wptr_q;
    assign ctl_o.mask    = mask;
    assign irq_o         = err_q & ie_q;

    // R3: the size select cannot move while the engine is enabled
    a_r3_size_frozen: assert property (@(posedge clk) disable iff (rst)
        run_q |=> $stable(sel_q));

    // R9: a failed fetch always leaves the engine stopped
    a_r9_err_stops: assert property (@(posedge clk) disable iff (rst)
        err_pulse_i |=> (err_q && !run_q));

endmodule

// File: rtl/cring_fetch.sv
module cring_fetch
    import cring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ring_ctl_t         ctl_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_ready,
    output logic [PTR_W-1:0]  rptr_o,
    output logic              busy_o,
    output logic              err_pulse_o
);

    localparam int WORD_SHIFT = $clog2(DATA_W / 8);

    fetch_state_e      state_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [DATA_W-1:0] data_q;
    logic [PTR_W-1:0]  slot;

    assign slot        = (rptr_q + PTR_W'(1)) & ctl_i.mask;
    assign mem_addr    = base_i + (ADDR_W'(slot) << WORD_SHIFT);
    assign mem_req     = (state_q == F_REQ);
    assign cmd_valid   = (state_q == F_HOLD);
    assign cmd_data    = data_q;
    assign rptr_o      = rptr_q;
    assign busy_o      = (state_q != F_IDLE);
    assign err_pulse_o = (state_q == F_REQ) && mem_ack && mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= F_IDLE;
            rptr_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                F_IDLE: begin
                    if (ctl_i.rst_req)
                        rptr_q <= '0;
                    else if (ctl_i.run && (ctl_i.wptr != rptr_q))
                        state_q <= F_REQ;
                end
                F_REQ: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state_q <= F_IDLE;
                        end else begin
                            data_q  <= mem_rdata;
                            state_q <= F_HOLD;
                        end
                    end
                end
                F_HOLD: begin
                    if (cmd_ready) begin
                        rptr_q  <= slot;
                        state_q <= F_IDLE;
                    end
                end
                default: state_q <= F_IDLE;
            endcase
        end
    end

    // R4: a read request stays up until memory acknowledges it
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R4: a presented command is stable until accepted
    a_r4_valid_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R4: the read pointer moves only on acceptance or on a reset request
    a_r4_rptr_on_accept: assert property (@(posedge clk) disable iff (rst)
        (!(cmd_valid && cmd_ready) && !ctl_i.rst_req) |=> $stable(rptr_q));

    // R9: a faulted read is never presented downstream
    a_r9_err_no_cmd: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (!cmd_valid && $stable(rptr_q)));

endmodule

// File: rtl/cring_engine.sv
module cring_engine
    import cring_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         DATA_W     = 32,
    parameter logic [2:0] SIZE_CAP   = 3'b111,
    parameter int         ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_ready,
    output logic              irq
);

    ring_ctl_t         ctl;
    logic [ADDR_W-1:0] base;
    logic [PTR_W-1:0]  rptr;
    logic              busy;
    logic              err_pulse;

    cring_regs #(
        .ADDR_W    (ADDR_W),
        .SIZE_CAP  (SIZE_CAP),
        .ALIGN_BITS(ALIGN_BITS)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rptr_i     (rptr),
        .busy_i     (busy),
        .err_pulse_i(err_pulse),
        .base_o     (base),
        .ctl_o      (ctl),
        .irq_o      (irq)
    );

    cring_fetch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) fetch_i (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .base_i     (base),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .cmd_ready  (cmd_ready),
        .rptr_o     (rptr),
        .busy_o     (busy),
        .err_pulse_o(err_pulse)
    );

    // R10: the interrupt is never raised while the engine is fetching normally from reset
    a_r10_irq_needs_fault: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(reg_we)) |-> $past(err_pulse));

endmodule

// File: tb/cring_engine_tb_top.sv
`timescale 1ns/1ps
module cring_engine_tb_top;
    import cring_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    cring_engine dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .irq(irq)
    );

    int          total = 0;
    int          bad = 0;
    logic [31:0] exp_q[$];
    logic [31:0] mem [256];
    logic [31:0] cur_base = 32'h0000_1000;
    logic        err_en = 1'b0;
    logic [7:0]  err_slot = '0;
    logic        hold_ready = 1'b0;
    logic        bp_mode = 1'b0;
    logic [7:0]  cyc = '0;
    int          len = 256;
    logic [7:0]  sw_wptr = '0;
    logic [31:0] seed = 32'hC0DE_0001;
    bit          finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: one-cycle acknowledge per request
    always @(posedge clk) begin
        logic [31:0] off;
        off = mem_addr - cur_base;
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem[off[9:2]];
            mem_err   <= err_en && (off[9:2] == err_slot);
            if (mem_req && !mem_ack && (off[1:0] != 2'b00 || off >= 32'd1024)) begin
                total++; bad++;
                $display("FAIL R4 address actual=%h expected=inside ring at %h", mem_addr, cur_base);
            end
        end
    end

    // downstream ready pattern
    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        cmd_ready <= hold_ready ? 1'b0 : (bp_mode ? (cyc[0] ^ cyc[2]) : 1'b1);
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cmd_valid && cmd_ready) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R4 unexpected command actual=%h expected=none", cmd_data);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (cmd_data !== e) begin
                    bad++;
                    $display("FAIL R4 command actual=%h expected=%h", cmd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push(input logic [31:0] c);
        logic [7:0] s;
        s = (sw_wptr + 8'd1) & 8'(len - 1);
        mem[s] = c;
        exp_q.push_back(c);
        sw_wptr = s;
        wr(RA_WPTR, {24'b0, s});
    endtask

    task automatic drain();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(RA_RPTR, v);
            if (v[7:0] == sw_wptr) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] next_cmd();
        seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]};
        return seed;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(RA_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(RA_STAT, v); chk("R1 stat", v, 32'h0);
        rd(RA_SIZE, v); chk("R1 size", v, 32'h72);
        rd(RA_WPTR, v); chk("R1 wptr", v, 32'h0);
        rd(RA_RPTR, v); chk("R1 rptr", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R11 base alignment
        wr(RA_BASE, 32'h1234_5FFF);
        rd(RA_BASE, v); chk("R11 base", v, 32'h1234_5F80);
        wr(RA_BASE, cur_base);

        // R2 unsupported code ignored, then 16 entries
        wr(RA_SIZE, 32'h3);
        rd(RA_SIZE, v); chk("R2 bad code", v, 32'h72);
        wr(RA_SIZE, 32'h1);
        rd(RA_SIZE, v); chk("R2 select16", v, 32'h71);
        len = 16;

        // R4 basic fetch
        wr(RA_CTRL, 32'h1);
        for (int i = 0; i < 5; i++) push(next_cmd());
        drain();
        rd(RA_RPTR, v); chk("R4 rptr", v, 32'h5);
        chk("R4 drained", exp_q.size(), 0);

        // R3 size write ignored while running
        wr(RA_SIZE, 32'h0);
        rd(RA_SIZE, v); chk("R3 size frozen", v, 32'h71);

        // R5 full boundary with a stopped engine
        wr(RA_CTRL, 32'h0);
        for (int i = 0; i < 15; i++) push(next_cmd());
        rd(RA_RPTR, v); chk("R5 full", v, 32'h4005);
        bp_mode = 1'b1;
        wr(RA_CTRL, 32'h1);
        drain();
        rd(RA_RPTR, v); chk("R2 wrap16", v, 32'h4);
        chk("R2 drained", exp_q.size(), 0);

        // R8 / R7 with a held command
        bp_mode = 1'b0; hold_ready = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) push(next_cmd());
        repeat (10) @(negedge clk);
        rd(RA_RPTR, v); chk("R4 held no advance", v, 32'h4);
        wr(RA_WPTR, 32'h4);
        rd(RA_WPTR, v); chk("R8 wptr kept", v, 32'h7);
        wr(RA_CTRL, 32'h0);
        rd(RA_CTRL, v); chk("R7 busy readback", v, 32'h1);
        hold_ready = 1'b0;
        repeat (10) @(negedge clk);
        rd(RA_CTRL, v); chk("R7 idle readback", v, 32'h0);
        rd(RA_RPTR, v); chk("R7 no further fetch", v, 32'h5);
        chk("R7 pending", exp_q.size(), 2);
        wr(RA_CTRL, 32'h1);
        drain();
        chk("R7 drained", exp_q.size(), 0);

        // R9 / R10 memory error
        err_en = 1'b1; err_slot = 8'd8;
        wr(RA_CTRL, 32'h3);
        x = next_cmd();
        mem[8] = x; sw_wptr = 8'd8;
        wr(RA_WPTR, 32'h8);
        repeat (20) @(negedge clk);
        rd(RA_STAT, v); chk("R9 flag", v, 32'h1);
        chk("R10 irq on", {31'b0, irq}, 32'h1);
        rd(RA_CTRL, v); chk("R9 run cleared", v, 32'h2);
        rd(RA_RPTR, v); chk("R9 rptr kept", v, 32'h7);
        wr(RA_STAT, 32'h1);
        rd(RA_STAT, v); chk("R9 w1c", v, 32'h0);
        chk("R10 irq off", {31'b0, irq}, 32'h0);
        err_en = 1'b0;
        exp_q.push_back(x);
        wr(RA_CTRL, 32'h3);
        drain();
        rd(RA_RPTR, v); chk("R9 retry", v, 32'h8);
        chk("R9 drained", exp_q.size(), 0);

        // R6 read pointer reset handshake
        wr(RA_CTRL, 32'h0);
        wr(RA_WPTR, 32'h0); sw_wptr = 8'd0;
        wr(RA_RPTR, 32'h8000);
        rd(RA_RPTR, v); chk("R6 ack set", v, 32'h8000);
        wr(RA_RPTR, 32'h0);
        rd(RA_RPTR, v); chk("R6 ack clear", v, 32'h0);

        // R2 two-entry ring with R5 full
        wr(RA_SIZE, 32'h0);
        rd(RA_SIZE, v); chk("R2 select2", v, 32'h70);
        len = 2;
        push(next_cmd());
        rd(RA_RPTR, v); chk("R5 full2", v, 32'h4000);
        wr(RA_CTRL, 32'h1);
        drain();
        push(next_cmd()); drain();
        push(next_cmd()); drain();
        rd(RA_RPTR, v); chk("R2 wrap2", v, 32'h1);
        chk("R2 drained2", exp_q.size(), 0);

        // R2 256-entry ring wrap under backpressure
        wr(RA_CTRL, 32'h0);
        wr(RA_SIZE, 32'h2);
        len = 256;
        bp_mode = 1'b1;
        wr(RA_CTRL, 32'h1);
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 100; i++) push(next_cmd());
            drain();
        end
        rd(RA_RPTR, v); chk("R2 wrap256", v, 32'd45);
        chk("R2 drained256", exp_q.size(), 0);

        summary();
    end

endmodule